// File: doc/BRIEF.md
# BCD Calendar Register File

This block keeps time of day and calendar date as thirteen packed-decimal digit registers. Software reaches them over a 4-bit multiplexed bus. A bus cycle first captures a register number with the address strobe. A write or read strobe then moves one nibble, and both chip selects must be high for any of this to happen. A one-cycle `tick_1hz` pulse advances the count. Each digit carries into the next: seconds, minutes, hours, then day with weekday, then month, then year. The day wraps at the true month length, and February gets its 29th day in the leap year that software selects.

The hour runs in either 24-hour or 12-hour form. The mode flag and the afternoon flag sit in the spare upper bits of the hour-tens register. The leap-phase select sits in the upper bits of the day-tens register. Two addresses hold no digit:
- Writing register 14 sends a one-cycle clear pulse to the external sub-second divider.
- Reading register 15 returns the divider's status nibble.

The bus is handled by a four-state sequencer:
- `ST_IDLE`: no address has been captured since reset.
- `ST_ADDR`: an address is held.
- `ST_WR`: a write strobe is being held.
- `ST_RD`: a read is being driven out.

Its transitions:
- `ST_IDLE` to `ST_ADDR` on a selected address strobe.
- `ST_ADDR` to `ST_WR` on a selected write strobe. The write takes effect on that edge.
- `ST_ADDR` to `ST_RD` on a selected read strobe.
- `ST_WR` and `ST_RD` back to `ST_ADDR` when the strobe or a select drops.

Top module: `bcd_rtc_regfile`

## Requirements
- R1: Registers 0 to 12 hold, in this order: seconds units, seconds tens, minutes units, minutes tens, hour units, hour tens, weekday, day units, day tens, month units, month tens, year units and year tens. A nibble written to one of them reads back unchanged, except for the flag rules in R5.
- R2: On a tick, seconds units wrap from 9 to 0 and carry into seconds tens. Seconds tens wrap from 5 to 0 and carry into minutes. The minute digits follow the same two rules and carry into the hour.
- R3: When bit 3 of hour tens is 1 (24-hour form), the hour counts 00 to 23. The step from 23 to 00 carries into the day.
- R4: When bit 3 of hour tens is 0 (12-hour form), the hour runs 12, 01, ..., 11. Bit 2 of hour tens (1 = afternoon) toggles on the step from 11 to 12. The day advances only when 11 in the afternoon becomes 12 (bit 2 clears).
- R5: Bit 3 of hour tens always reads 0. Bit 2 of hour tens reads 0 while 24-hour form is selected. Bits 1..0 read as the tens value.
- R6: The day wraps to 01 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except February. February wraps after day 28, or after day 29 when the year mod 4 equals the remainder that bits 3..2 of day tens select: 00 selects 0, 01 selects 3, 10 selects 2, 11 selects 1.
- R7: The weekday (0 to 6) advances with every day step and wraps from 6 to 0.
- R8: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R9: A bus write to a digit in the same cycle as a tick stores the written value in that digit. The other digits still take their tick update.
- R10: A write to register 14 makes `presc_clr` high for exactly one cycle, the cycle after the write edge. A tick in the write cycle is discarded.
- R11: Reading register 15 returns `std_in`. Register 13 reads 0 and ignores writes. Register 14 reads 0.
- R12: Address capture, writes and reads need both `cs_a` and `cs_b` high. A write with either one low changes nothing.
- R13: After reset the registers read as 00:00:00, weekday 0, day 01, month 01, year 00, 24-hour form, leap select 00.
- R14: `dout_en` is high and `dout` carries the addressed nibble only in the cycles after a selected read strobe has been seen (`ST_RD`). Otherwise `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_a | input | 1 | Chip select one, active high |
| cs_b | input | 1 | Chip select two, active high |
| adr_wr | input | 1 | Address capture strobe |
| addr_in | input | 4 | Register number |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| din | input | 4 | Write data nibble |
| dout | output | 4 | Read data nibble, 0 when not reading |
| dout_en | output | 1 | High while read data is driven |
| tick_1hz | input | 1 | One-cycle pulse per second |
| std_in | input | 4 | Divider status nibble returned by register 15 |
| presc_clr | output | 1 | One-cycle clear pulse for the divider |

## Verification
Two functions can land on the same clock edge: a bus write and a tick, or a write to register 14 and a tick. The bench holds `tick_1hz` high on the very edge where the write strobe is first seen.
- For a digit write, the check is that the written digit keeps the bus value while its neighbour takes the tick carry.
- For a register-14 write, the check is that `presc_clr` pulses for one cycle and the seconds do not move.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NIB_W  = 4;
    localparam int ADR_W  = 4;

    localparam logic [ADR_W-1:0] A_S1   = 4'h0;
    localparam logic [ADR_W-1:0] A_S10  = 4'h1;
    localparam logic [ADR_W-1:0] A_MI1  = 4'h2;
    localparam logic [ADR_W-1:0] A_MI10 = 4'h3;
    localparam logic [ADR_W-1:0] A_H1   = 4'h4;
    localparam logic [ADR_W-1:0] A_H10  = 4'h5;
    localparam logic [ADR_W-1:0] A_WD   = 4'h6;
    localparam logic [ADR_W-1:0] A_D1   = 4'h7;
    localparam logic [ADR_W-1:0] A_D10  = 4'h8;
    localparam logic [ADR_W-1:0] A_MO1  = 4'h9;
    localparam logic [ADR_W-1:0] A_MO10 = 4'hA;
    localparam logic [ADR_W-1:0] A_Y1   = 4'hB;
    localparam logic [ADR_W-1:0] A_Y10  = 4'hC;
    localparam logic [ADR_W-1:0] A_CLR  = 4'hE;
    localparam logic [ADR_W-1:0] A_STD  = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WR   = 2'd2,
        ST_RD   = 2'd3
    } bus_st_e;

    typedef struct packed {
        logic       m24;
        logic       pm;
        logic [1:0] ph;
        logic [3:0] y10;
        logic [3:0] y1;
        logic       mo10;
        logic [3:0] mo1;
        logic [1:0] d10;
        logic [3:0] d1;
        logic [2:0] w;
        logic [1:0] h10;
        logic [3:0] h1;
        logic [2:0] mi10;
        logic [3:0] mi1;
        logic [2:0] s10;
        logic [3:0] s1;
    } rtc_time_t;
endpackage

// File: rtl/rtc_bus_fsm.sv
module rtc_bus_fsm
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_a,
    input  logic             cs_b,
    input  logic             adr_wr,
    input  logic [ADR_W-1:0] addr_in,
    input  logic             wr_stb,
    input  logic             rd_stb,
    output logic [ADR_W-1:0] lat_addr,
    output logic             wr_fire,
    output logic             rd_act
);
    bus_st_e st, st_nx;
    logic    sel;

    assign sel = cs_a && cs_b;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (sel && adr_wr) st_nx = ST_ADDR;
            ST_ADDR: begin
                if (sel && wr_stb && !rd_stb)      st_nx = ST_WR;
                else if (sel && rd_stb && !wr_stb) st_nx = ST_RD;
            end
            ST_WR:   if (!wr_stb || !sel) st_nx = ST_ADDR;
            ST_RD:   if (!rd_stb || !sel) st_nx = ST_ADDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            lat_addr <= '0;
        end else begin
            st <= st_nx;
            if (sel && adr_wr && (st == ST_IDLE || st == ST_ADDR))
                lat_addr <= addr_in;
        end
    end

    always_comb begin
        wr_fire = 1'b0;
        rd_act  = 1'b0;
        unique case (st)
            ST_IDLE: ;
            ST_ADDR: wr_fire = sel && wr_stb && !rd_stb;
            ST_WR:   ;
            ST_RD:   rd_act = 1'b1;
        endcase
    end

    p_rd_after_strobe_r14: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |-> $past(rd_stb && cs_a && cs_b));
    p_wr_needs_both_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WR && $past(st) == ST_ADDR) |-> $past(cs_a && cs_b && wr_stb));
endmodule

// File: rtl/rtc_digit_chain.sv
module rtc_digit_chain
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             we,
    input  logic [ADR_W-1:0] waddr,
    input  logic [NIB_W-1:0] wdata,
    output rtc_time_t        t
);
    rtc_time_t  nx;
    logic       cy_s1, cy_s10, cy_mi1, hr_cy, day_cy, mo_cy, yr_cy;
    logic       is_feb, is_thirty, leap;
    logic [1:0] yr_rem;
    logic [1:0] last_d10;
    logic [3:0] last_d1;

    assign yr_rem    = {t.y10[0], 1'b0} + t.y1[1:0];
    assign leap      = (yr_rem == (2'd0 - t.ph));
    assign is_feb    = !t.mo10 && t.mo1 == 4'd2;
    assign is_thirty = (!t.mo10 && (t.mo1 == 4'd4 || t.mo1 == 4'd6 || t.mo1 == 4'd9))
                     || (t.mo10 && t.mo1 == 4'd1);

    always_comb begin
        if (is_feb) begin
            last_d10 = 2'd2;
            last_d1  = leap ? 4'd9 : 4'd8;
        end else begin
            last_d10 = 2'd3;
            last_d1  = is_thirty ? 4'd0 : 4'd1;
        end
    end

    always_comb begin
        nx     = t;
        day_cy = 1'b0;
        mo_cy  = 1'b0;
        yr_cy  = 1'b0;
        cy_s1  = tick && t.s1 == 4'd9;
        cy_s10 = cy_s1 && t.s10 == 3'd5;
        cy_mi1 = cy_s10 && t.mi1 == 4'd9;
        hr_cy  = cy_mi1 && t.mi10 == 3'd5;
        if (tick)   nx.s1   = cy_s1  ? 4'd0 : t.s1 + 4'd1;
        if (cy_s1)  nx.s10  = cy_s10 ? 3'd0 : t.s10 + 3'd1;
        if (cy_s10) nx.mi1  = cy_mi1 ? 4'd0 : t.mi1 + 4'd1;
        if (cy_mi1) nx.mi10 = hr_cy  ? 3'd0 : t.mi10 + 3'd1;
        if (hr_cy) begin
            if (t.m24) begin
                if (t.h10 == 2'd2 && t.h1 == 4'd3) begin
                    nx.h10 = 2'd0; nx.h1 = 4'd0; day_cy = 1'b1;
                end else if (t.h1 == 4'd9) begin
                    nx.h1 = 4'd0; nx.h10 = t.h10 + 2'd1;
                end else nx.h1 = t.h1 + 4'd1;
            end else begin
                if (t.h10 == 2'd1 && t.h1 == 4'd1) begin
                    nx.h1 = 4'd2; nx.pm = !t.pm; day_cy = t.pm;
                end else if (t.h10 == 2'd1 && t.h1 == 4'd2) begin
                    nx.h10 = 2'd0; nx.h1 = 4'd1;
                end else if (t.h1 == 4'd9) begin
                    nx.h1 = 4'd0; nx.h10 = 2'd1;
                end else nx.h1 = t.h1 + 4'd1;
            end
        end
        if (day_cy) begin
            nx.w = (t.w == 3'd6) ? 3'd0 : t.w + 3'd1;
            if (t.d10 == last_d10 && t.d1 == last_d1) begin
                nx.d10 = 2'd0; nx.d1 = 4'd1; mo_cy = 1'b1;
            end else if (t.d1 == 4'd9) begin
                nx.d1 = 4'd0; nx.d10 = t.d10 + 2'd1;
            end else nx.d1 = t.d1 + 4'd1;
        end
        if (mo_cy) begin
            if (t.mo10 && t.mo1 == 4'd2) begin
                nx.mo10 = 1'b0; nx.mo1 = 4'd1; yr_cy = 1'b1;
            end else if (t.mo1 == 4'd9) begin
                nx.mo1 = 4'd0; nx.mo10 = 1'b1;
            end else nx.mo1 = t.mo1 + 4'd1;
        end
        if (yr_cy) begin
            if (t.y1 == 4'd9) begin
                nx.y1  = 4'd0;
                nx.y10 = (t.y10 == 4'd9) ? 4'd0 : t.y10 + 4'd1;
            end else nx.y1 = t.y1 + 4'd1;
        end
        if (we) begin
            case (waddr)
                A_S1:   nx.s1   = wdata;
                A_S10:  nx.s10  = wdata[2:0];
                A_MI1:  nx.mi1  = wdata;
                A_MI10: nx.mi10 = wdata[2:0];
                A_H1:   nx.h1   = wdata;
                A_H10:  begin nx.m24 = wdata[3]; nx.pm = wdata[2]; nx.h10 = wdata[1:0]; end
                A_WD:   nx.w    = wdata[2:0];
                A_D1:   nx.d1   = wdata;
                A_D10:  begin nx.ph = wdata[3:2]; nx.d10 = wdata[1:0]; end
                A_MO1:  nx.mo1  = wdata;
                A_MO10: nx.mo10 = wdata[0];
                A_Y1:   nx.y1   = wdata;
                A_Y10:  nx.y10  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t     <= '0;
            t.m24 <= 1'b1;
            t.d1  <= 4'd1;
            t.mo1 <= 4'd1;
        end else begin
            t <= nx;
        end
    end

    p_sec_units_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && t.s1 == 4'd9 && !(we && waddr == A_S1)) |=> (t.s1 == 4'd0));
    p_hour24_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_cy && t.m24 && t.h10 == 2'd2 && t.h1 == 4'd3
         && !(we && (waddr == A_H1 || waddr == A_H10))) |=> (t.h10 == 2'd0 && t.h1 == 4'd0));
    p_pm_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_cy && !t.m24 && t.h10 == 2'd1 && t.h1 == 4'd1 && !(we && waddr == A_H10))
        |=> (t.pm != $past(t.pm)));
    p_wday_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (day_cy && t.w == 3'd6 && !(we && waddr == A_WD)) |=> (t.w == 3'd0));
endmodule

// File: rtl/bcd_rtc_regfile.sv
module bcd_rtc_regfile
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_a,
    input  logic             cs_b,
    input  logic             adr_wr,
    input  logic [ADR_W-1:0] addr_in,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [NIB_W-1:0] din,
    output logic [NIB_W-1:0] dout,
    output logic             dout_en,
    input  logic             tick_1hz,
    input  logic [NIB_W-1:0] std_in,
    output logic             presc_clr
);
    logic [ADR_W-1:0] lat_addr;
    logic             wr_fire, rd_act, clr_fire, digit_we, tick_eff;
    rtc_time_t        tm;
    logic [NIB_W-1:0] rd_mux;

    rtc_bus_fsm u_bus (
        .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b), .adr_wr(adr_wr),
        .addr_in(addr_in), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .lat_addr(lat_addr), .wr_fire(wr_fire), .rd_act(rd_act)
    );

    assign clr_fire = wr_fire && lat_addr == A_CLR;
    assign digit_we = wr_fire && lat_addr <= A_Y10;
    assign tick_eff = tick_1hz && !clr_fire;

    rtc_digit_chain u_chain (
        .clk(clk), .rst_n(rst_n), .tick(tick_eff), .we(digit_we),
        .waddr(lat_addr), .wdata(din), .t(tm)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_clr <= 1'b0;
        else        presc_clr <= clr_fire;
    end

    always_comb begin
        rd_mux = '0;
        case (lat_addr)
            A_S1:   rd_mux = tm.s1;
            A_S10:  rd_mux = {1'b0, tm.s10};
            A_MI1:  rd_mux = tm.mi1;
            A_MI10: rd_mux = {1'b0, tm.mi10};
            A_H1:   rd_mux = tm.h1;
            A_H10:  rd_mux = {1'b0, tm.pm && !tm.m24, tm.h10};
            A_WD:   rd_mux = {1'b0, tm.w};
            A_D1:   rd_mux = tm.d1;
            A_D10:  rd_mux = {tm.ph, tm.d10};
            A_MO1:  rd_mux = tm.mo1;
            A_MO10: rd_mux = {3'b000, tm.mo10};
            A_Y1:   rd_mux = tm.y1;
            A_Y10:  rd_mux = tm.y10;
            A_STD:  rd_mux = std_in;
            default: rd_mux = '0;
        endcase
    end

    assign dout    = rd_act ? rd_mux : '0;
    assign dout_en = rd_act;

    p_clr_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        presc_clr |=> !presc_clr);
    p_clr_freezes_seconds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> $stable(tm.s1));
endmodule

// File: tb/bcd_rtc_regfile_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_a = 1'b1, cs_b = 1'b1, adr_wr = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [3:0] addr_in = '0, din = '0, std_in = 4'hA;
    logic [3:0] dout;
    logic       dout_en, presc_clr;
    int         n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    bcd_rtc_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b), .adr_wr(adr_wr),
        .addr_in(addr_in), .wr_stb(wr_stb), .rd_stb(rd_stb), .din(din),
        .dout(dout), .dout_en(dout_en), .tick_1hz(tick_1hz), .std_in(std_in),
        .presc_clr(presc_clr)
    );

    typedef struct packed {
        bit       m24;
        bit       pm;
        bit [1:0] ph;
        bit [7:0] yy, mo, dd;
        bit [3:0] wd;
        bit [7:0] hh, mm, ss;
    } tv_t;
    typedef struct packed { tv_t pre; tv_t post; } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{'{1,0,2'd0,8'h99,8'h12,8'h31,4'd6,8'h23,8'h59,8'h59}, '{1,0,2'd0,8'h00,8'h01,8'h01,4'd0,8'h00,8'h00,8'h00}},
        '{'{1,0,2'd0,8'h21,8'h06,8'h15,4'd2,8'h09,8'h59,8'h59}, '{1,0,2'd0,8'h21,8'h06,8'h15,4'd2,8'h10,8'h00,8'h00}},
        '{'{0,0,2'd0,8'h22,8'h03,8'h10,4'd3,8'h11,8'h59,8'h59}, '{0,1,2'd0,8'h22,8'h03,8'h10,4'd3,8'h12,8'h00,8'h00}},
        '{'{0,1,2'd0,8'h22,8'h03,8'h10,4'd3,8'h11,8'h59,8'h59}, '{0,0,2'd0,8'h22,8'h03,8'h11,4'd4,8'h12,8'h00,8'h00}},
        '{'{0,1,2'd0,8'h22,8'h03,8'h10,4'd3,8'h12,8'h59,8'h59}, '{0,1,2'd0,8'h22,8'h03,8'h10,4'd3,8'h01,8'h00,8'h00}},
        '{'{1,0,2'd0,8'h23,8'h02,8'h28,4'd1,8'h23,8'h59,8'h59}, '{1,0,2'd0,8'h23,8'h03,8'h01,4'd2,8'h00,8'h00,8'h00}},
        '{'{1,0,2'd0,8'h24,8'h02,8'h28,4'd1,8'h23,8'h59,8'h59}, '{1,0,2'd0,8'h24,8'h02,8'h29,4'd2,8'h00,8'h00,8'h00}},
        '{'{1,0,2'd1,8'h23,8'h02,8'h28,4'd1,8'h23,8'h59,8'h59}, '{1,0,2'd1,8'h23,8'h02,8'h29,4'd2,8'h00,8'h00,8'h00}},
        '{'{1,0,2'd0,8'h05,8'h04,8'h30,4'd5,8'h23,8'h59,8'h59}, '{1,0,2'd0,8'h05,8'h05,8'h01,4'd6,8'h00,8'h00,8'h00}},
        '{'{1,0,2'd2,8'h22,8'h02,8'h29,4'd0,8'h23,8'h59,8'h59}, '{1,0,2'd2,8'h22,8'h03,8'h01,4'd1,8'h00,8'h00,8'h00}},
        '{'{1,0,2'd0,8'h00,8'h01,8'h01,4'd0,8'h00,8'h00,8'h09}, '{1,0,2'd0,8'h00,8'h01,8'h01,4'd0,8'h00,8'h00,8'h10}},
        '{'{1,0,2'd0,8'h10,8'h01,8'h31,4'd4,8'h23,8'h59,8'h59}, '{1,0,2'd0,8'h10,8'h02,8'h01,4'd5,8'h00,8'h00,8'h00}},
        '{'{1,0,2'd3,8'h19,8'h09,8'h30,4'd6,8'h23,8'h59,8'h59}, '{1,0,2'd3,8'h19,8'h10,8'h01,4'd0,8'h00,8'h00,8'h00}},
        '{'{0,0,2'd0,8'h30,8'h07,8'h04,4'd2,8'h09,8'h59,8'h59}, '{0,0,2'd0,8'h30,8'h07,8'h04,4'd2,8'h10,8'h00,8'h00}}
    };

    function automatic logic [3:0] nib(tv_t t, int a, bit for_write);
        case (a)
            0:  return t.ss[3:0];
            1:  return t.ss[7:4];
            2:  return t.mm[3:0];
            3:  return t.mm[7:4];
            4:  return t.hh[3:0];
            5:  return for_write ? {t.m24, t.pm, t.hh[5:4]} : {1'b0, t.pm && !t.m24, t.hh[5:4]};
            6:  return t.wd;
            7:  return t.dd[3:0];
            8:  return {t.ph, t.dd[5:4]};
            9:  return t.mo[3:0];
            10: return {3'b000, t.mo[4]};
            11: return t.yy[3:0];
            default: return t.yy[7:4];
        endcase
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d, input bit with_tick);
        @(negedge clk); addr_in = a; adr_wr = 1'b1;
        @(negedge clk); adr_wr = 1'b0; din = d; wr_stb = 1'b1; tick_1hz = with_tick;
        @(negedge clk); wr_stb = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] q);
        @(negedge clk); addr_in = a; adr_wr = 1'b1;
        @(negedge clk); adr_wr = 1'b0; rd_stb = 1'b1;
        @(negedge clk); q = dout;
        if (!dout_en) begin
            n_err++;
            $display("FAIL R14: dout_en got 0 expected 1");
        end
        rd_stb = 1'b0;
        @(negedge clk);
        chk("R14 dout idle", {dout_en, dout[2:0]}, 4'h0);
    endtask

    task automatic tick_once();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [3:0] q;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13 reset state, R14 idle output
        chk("R14 dout before read", dout, 4'h0);
        rd(4'h0, q); chk("R13 S1 reset", q, 4'h0);
        rd(4'h5, q); chk("R13 H10 reset", q, 4'h0);
        rd(4'h6, q); chk("R13 W reset", q, 4'h0);
        rd(4'h7, q); chk("R13 D1 reset", q, 4'h1);
        rd(4'h9, q); chk("R13 MO1 reset", q, 4'h1);
        rd(4'h8, q); chk("R13 D10 reset", q, 4'h0);

        // Vector table: R1..R4, R6..R8
        for (int v = 0; v < NV; v++) begin
            for (int a = 0; a < 13; a++) wr(4'(a), nib(VEC[v].pre, a, 1'b1), 1'b0);
            tick_once();
            for (int a = 0; a < 13; a++) begin
                rd(4'(a), q);
                chk($sformatf("R1 R2 R3 R4 R6 R7 R8 vec %0d reg %0d", v, a), q, nib(VEC[v].post, a, 1'b0));
            end
        end

        // R5 flag readback
        wr(4'h5, 4'b1110, 1'b0); rd(4'h5, q); chk("R5 24h hides mode and pm", q, 4'b0010);
        wr(4'h5, 4'b0101, 1'b0); rd(4'h5, q); chk("R5 12h shows pm", q, 4'b0101);

        // R11 spare, clear and status registers
        wr(4'hD, 4'hF, 1'b0); rd(4'hD, q); chk("R11 spare reads 0", q, 4'h0);
        rd(4'hE, q); chk("R11 clear reg reads 0", q, 4'h0);
        std_in = 4'h6; rd(4'hF, q); chk("R11 status nibble", q, 4'h6);

        // R12 chip selects
        wr(4'h0, 4'h3, 1'b0);
        cs_b = 1'b0; wr(4'h0, 4'h8, 1'b0); cs_b = 1'b1;
        rd(4'h0, q); chk("R12 cs_b low blocks write", q, 4'h3);
        cs_a = 1'b0; wr(4'h0, 4'h8, 1'b0); cs_a = 1'b1;
        rd(4'h0, q); chk("R12 cs_a low blocks write", q, 4'h3);

        // R9 write vs tick on the same edge
        wr(4'h0, 4'h9, 1'b0); wr(4'h1, 4'h0, 1'b0);
        wr(4'h1, 4'h4, 1'b1);
        rd(4'h0, q); chk("R9 neighbour takes tick", q, 4'h0);
        rd(4'h1, q); chk("R9 written digit wins", q, 4'h4);
        wr(4'h0, 4'h3, 1'b0);
        wr(4'h0, 4'h7, 1'b1);
        rd(4'h0, q); chk("R9 written units win", q, 4'h7);
        rd(4'h1, q); chk("R9 tens untouched", q, 4'h4);

        // R10 clear pulse with concurrent tick
        wr(4'h0, 4'h5, 1'b0);
        @(negedge clk); addr_in = 4'hE; adr_wr = 1'b1;
        @(negedge clk); adr_wr = 1'b0; wr_stb = 1'b1; tick_1hz = 1'b1;
        chk("R10 no pulse before edge", {3'b000, presc_clr}, 4'h0);
        @(negedge clk); wr_stb = 1'b0; tick_1hz = 1'b0;
        chk("R10 pulse high", {3'b000, presc_clr}, 4'h1);
        @(negedge clk);
        chk("R10 pulse one cycle", {3'b000, presc_clr}, 4'h0);
        rd(4'h0, q); chk("R10 tick discarded", q, 4'h5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule